// File: doc/BRIEF.md
# Free-Running Timer with Edge Capture

This block keeps a 16-bit up-counter that advances on a divided version of an incoming tick enable. Software reaches the counter through two byte-wide registers. A read of the low byte freezes the upper byte in a shadow, and a write of the upper byte commits a previously buffered low byte. Both directions are therefore atomic across the two byte accesses.

Two timer input pins are synchronized and edge-detected. On each rising edge and on each falling edge of a pin, a selectable 8-bit window of the counter is stored in a read-only register kept for that pin and that edge polarity. Every capture also raises a sticky interrupt flag. Software clears the flag by writing a one to it.

The bus is a simple strobe interface. Read data appears one cycle after the read strobe and holds until the next read.

Top module: `fcap_timer`

## Requirements
- R1: While no upper-byte write occurs, the counter increases by exactly one on each divided tick and holds otherwise. It wraps from 0xFFFF to 0x0000.
- R2: The tick enable is divided by 2, 4, 6 or 8, selected by config bits [4:3] = 0, 1, 2, 3. The division phase restarts on every upper-byte write.
- R3: Reading address 0 returns counter bits [7:0] and latches bits [15:8] into a shadow. Reading address 1 returns that shadow, even if the counter has since moved.
- R4: Writing address 0 only buffers the byte and leaves the counter unchanged. Writing address 1 loads {written byte, buffered byte} into the counter in one cycle, and this load overrides any increment.
- R5: Config bits [2:0] hold a value n, and a capture stores counter bits [n+7:n]. Any shift that would pass the top bit saturates at [15:8]. The config register reads back at address 2, with zeros above bit 4.
- R6: After a two-flop synchronizer, a rising edge on pin k stores the selected counter window at address 4+2k, and a falling edge stores it at address 5+2k. Writes to these addresses have no effect.
- R7: Each capture sets a sticky flag: bit 2k for a rising edge on pin k, bit 2k+1 for a falling edge. The flags appear on cap_irq and read at address 3. Writing a one to a flag bit at address 3 clears that bit. When a set and a clear of the same bit arrive in the same cycle, the set wins.
- R8: After reset, the counter, the config, all captures and all flags are zero.
- R9: A pin held at a steady level causes no further capture and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| cap_pin | input | 2 | Timer input pins, asynchronous |
| tick_en | input | 1 | Capture-clock enable before division |
| cap_irq | output | 4 | Sticky capture flags |

## Verification
Captures are exercised with random counter values, random window selections and random pins. The counter is frozen during each capture, so the stored byte is known exactly. This separates a wrong window shift from a wrong pin or a wrong polarity, and a wrong polarity from a flag raised on the wrong bit. Directed runs count ticks under each divider setting and across the 0xFFFF wrap. A directed run moves the counter between the low and high reads to show the shadow at work. Other directed runs check the buffered low write, writes aimed at the read-only captures, and a steady pin after a flag has been cleared.

// File: rtl/fcap_pkg.sv
package fcap_pkg;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] A_CNT_LO   = 4'd0;
   localparam logic [ADDR_W-1:0] A_CNT_HI   = 4'd1;
   localparam logic [ADDR_W-1:0] A_CFG      = 4'd2;
   localparam logic [ADDR_W-1:0] A_FLAGS    = 4'd3;
   localparam logic [ADDR_W-1:0] A_CAP_BASE = 4'd4;
endpackage

// File: rtl/fcap_tick_div.sv
module fcap_tick_div #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [DIV_W-1:0] div_sel,
   input  logic             restart,
   output logic             inc
);
   localparam int PH_W = DIV_W + 1;

   logic [PH_W-1:0] phase;
   logic [PH_W-1:0] limit;

   // divisor 2*(sel+1): terminal phase is 2*sel+1
   assign limit = {div_sel, 1'b1};
   assign inc   = tick_en && (phase >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (restart) begin
         phase <= '0;
      end else if (tick_en) begin
         phase <= inc ? '0 : phase + 1'b1;
      end
   end

   assert_restart_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !inc);
endmodule

// File: rtl/fcap_counter.sv
module fcap_counter #(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                inc,
   input  logic                wr_lo,
   input  logic                wr_hi,
   input  logic                rd_lo,
   input  logic [BYTE_W-1:0]   wdata,
   output logic [2*BYTE_W-1:0] count,
   output logic [BYTE_W-1:0]   shadow
);
   localparam int CNT_W = 2 * BYTE_W;

   logic [BYTE_W-1:0] lo_buf;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count  <= '0;
         lo_buf <= '0;
         shadow <= '0;
      end else begin
         if (wr_lo) lo_buf <= wdata;
         if (wr_hi)    count <= {wdata, lo_buf};
         else if (inc) count <= count + 1'b1;
         if (rd_lo) shadow <= count[CNT_W-1:BYTE_W];
      end
   end

   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_hi) |=> count == $past(count) + 1'b1);
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !wr_hi) |=> $stable(count));
   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> count == {$past(wdata), $past(lo_buf)});
   assert_shadow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> shadow == $past(count[CNT_W-1:BYTE_W]));
endmodule

// File: rtl/fcap_capture_chan.sv
module fcap_capture_chan #(
   parameter int BYTE_W = 8,
   parameter int PS_W   = 3,
   parameter int SYNC_N = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pin,
   input  logic [2*BYTE_W-1:0] count,
   input  logic [PS_W-1:0]     ps,
   input  logic                clr_rise,
   input  logic                clr_fall,
   output logic [BYTE_W-1:0]   rise_q,
   output logic [BYTE_W-1:0]   fall_q,
   output logic                flag_rise,
   output logic                flag_fall
);
   localparam int CNT_W     = 2 * BYTE_W;
   localparam int MAX_SHIFT = CNT_W - BYTE_W;

   logic [SYNC_N-1:0] chain;
   logic              prev;
   logic              rise_ev, fall_ev;
   logic [BYTE_W-1:0] window;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[SYNC_N-2:0], pin};
         prev  <= chain[SYNC_N-1];
      end
   end

   assign rise_ev = chain[SYNC_N-1] & ~prev;
   assign fall_ev = ~chain[SYNC_N-1] & prev;

   always_comb begin
      logic [CNT_W-1:0] shifted;
      if (int'(ps) > MAX_SHIFT) shifted = count >> MAX_SHIFT;
      else                      shifted = count >> ps;
      window = shifted[BYTE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rise_q    <= '0;
         fall_q    <= '0;
         flag_rise <= 1'b0;
         flag_fall <= 1'b0;
      end else begin
         if (rise_ev) rise_q <= window;
         if (fall_ev) fall_q <= window;
         flag_rise <= rise_ev | (flag_rise & ~clr_rise);
         flag_fall <= fall_ev | (flag_fall & ~clr_fall);
      end
   end

   assert_edge_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_ev && fall_ev));
   assert_rise_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_ev |=> $stable(rise_q));
   assert_fall_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_ev |=> $stable(fall_q));
   assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rise_ev |=> flag_rise);
   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_fall && !clr_fall) |=> flag_fall);
   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_rise && !rise_ev) |=> !flag_rise);
endmodule

// File: rtl/fcap_timer.sv
module fcap_timer #(
   parameter int BYTE_W = 8,
   parameter int NUM_IN = 2,
   parameter int PS_W   = 3,
   parameter int DIV_W  = 2,
   parameter int SYNC_N = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_wr,
   input  logic                          bus_rd,
   input  logic [fcap_pkg::ADDR_W-1:0]   bus_addr,
   input  logic [BYTE_W-1:0]             bus_wdata,
   output logic [BYTE_W-1:0]             bus_rdata,
   input  logic [NUM_IN-1:0]             cap_pin,
   input  logic                          tick_en,
   output logic [2*NUM_IN-1:0]           cap_irq
);
   import fcap_pkg::*;

   localparam int CNT_W  = 2 * BYTE_W;
   localparam int FLAG_N = 2 * NUM_IN;
   localparam int CFG_W  = PS_W + DIV_W;

   if (BYTE_W < 4)                    begin : g_chk_byte $error("BYTE_W too small"); end
   if (FLAG_N > BYTE_W)               begin : g_chk_flag $error("too many inputs for flag byte"); end
   if (CFG_W > BYTE_W)                begin : g_chk_cfg  $error("config fields exceed a byte"); end
   if (4 + FLAG_N > (1 << ADDR_W))    begin : g_chk_addr $error("captures exceed address space"); end
   if (SYNC_N < 2)                    begin : g_chk_sync $error("synchronizer needs two stages"); end

   logic              wr_lo, wr_hi, wr_cfg, wr_flags, rd_lo;
   logic [PS_W-1:0]   cfg_ps;
   logic [DIV_W-1:0]  cfg_div;
   logic              inc;
   logic [CNT_W-1:0]  count;
   logic [BYTE_W-1:0] shadow;
   logic [BYTE_W-1:0] rise_q [NUM_IN];
   logic [BYTE_W-1:0] fall_q [NUM_IN];
   logic [FLAG_N-1:0] flags;
   logic [BYTE_W-1:0] rd_mux;
   logic [ADDR_W-1:0] cap_off;

   assign wr_lo    = bus_wr && (bus_addr == A_CNT_LO);
   assign wr_hi    = bus_wr && (bus_addr == A_CNT_HI);
   assign wr_cfg   = bus_wr && (bus_addr == A_CFG);
   assign wr_flags = bus_wr && (bus_addr == A_FLAGS);
   assign rd_lo    = bus_rd && (bus_addr == A_CNT_LO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_ps  <= '0;
         cfg_div <= '0;
      end else if (wr_cfg) begin
         cfg_ps  <= bus_wdata[PS_W-1:0];
         cfg_div <= bus_wdata[CFG_W-1:PS_W];
      end
   end

   fcap_tick_div #(.DIV_W(DIV_W)) i_div (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_sel(cfg_div),
      .restart(wr_hi), .inc(inc));

   fcap_counter #(.BYTE_W(BYTE_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .rd_lo(rd_lo), .wdata(bus_wdata), .count(count), .shadow(shadow));

   for (genvar k = 0; k < NUM_IN; k++) begin : g_chan
      fcap_capture_chan #(.BYTE_W(BYTE_W), .PS_W(PS_W), .SYNC_N(SYNC_N)) i_chan (
         .clk(clk), .rst_n(rst_n), .pin(cap_pin[k]), .count(count), .ps(cfg_ps),
         .clr_rise(wr_flags && bus_wdata[2*k]),
         .clr_fall(wr_flags && bus_wdata[2*k+1]),
         .rise_q(rise_q[k]), .fall_q(fall_q[k]),
         .flag_rise(flags[2*k]), .flag_fall(flags[2*k+1]));
   end

   assign cap_irq = flags;
   assign cap_off = bus_addr - A_CAP_BASE;

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         A_CNT_LO: rd_mux = count[BYTE_W-1:0];
         A_CNT_HI: rd_mux = shadow;
         A_CFG:    rd_mux = BYTE_W'({cfg_div, cfg_ps});
         A_FLAGS:  rd_mux = BYTE_W'(flags);
         default: begin
            for (int k = 0; k < NUM_IN; k++) begin
               if (cap_off == ADDR_W'(2*k))     rd_mux = rise_q[k];
               if (cap_off == ADDR_W'(2*k + 1)) rd_mux = fall_q[k];
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   assert_rdata_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
   assert_cfg_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cfg |=> $stable(cfg_ps));
endmodule

// File: tb/test_fcap_timer.sv
module test_fcap_timer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] cap_pin = '0;
   logic       tick_en = 1'b0;
   logic [3:0] cap_irq;

   int n_checks = 0;
   int n_fail   = 0;
   logic [7:0] exp_cap [4];
   logic [3:0] exp_flags;

   always #(CLK_PERIOD/2) clk = ~clk;

   fcap_timer i_fcap_timer (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_pin(cap_pin), .tick_en(tick_en), .cap_irq(cap_irq));

   function automatic logic [7:0] exp_window(logic [15:0] c, int ps);
      int sh = (ps > 8) ? 8 : ps;
      logic [15:0] s = c >> sh;
      return s[7:0];
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic set_count(logic [15:0] v);
      wr(4'd0, v[7:0]);
      wr(4'd1, v[15:8]);
   endtask

   task automatic read_count(output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(4'd0, lo);
      rd(4'd1, hi);
      v = {hi, lo};
   endtask

   task automatic run_ticks(int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic finish_test();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_test();
   end

   initial begin
      logic [7:0]  d;
      logic [15:0] v;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) exp_cap[i] = '0;
      exp_flags = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R8 reset state
      read_count(v);  check("R8 count", v, 16'h0000);
      rd(4'd2, d);    check("R8 config", {8'h0, d}, 16'h0);
      rd(4'd3, d);    check("R8 flags", {8'h0, d}, 16'h0);
      for (int a = 4; a < 8; a++) begin
         rd(4'(a), d); check("R8 capture", {8'h0, d}, 16'h0);
      end
      check("R8 irq", {12'h0, cap_irq}, 16'h0);

      // R4 buffered low write
      wr(4'd0, 8'h34);
      read_count(v);  check("R4 low write alone", v, 16'h0000);
      wr(4'd1, 8'h12);
      read_count(v);  check("R4 high write commits", v, 16'h1234);

      // R1/R2 counting under each divider
      for (int sel = 0; sel < 4; sel++) begin
         int m = 5 + int'($urandom_range(0, 20));
         wr(4'd2, 8'(sel << 3));
         set_count(16'h0100);
         run_ticks(m);
         read_count(v);
         check("R2 divided count", v, 16'h0100 + 16'(m / (2 * (sel + 1))));
      end
      rd(4'd2, d); check("R5 config readback", {8'h0, d}, 16'h0018);

      // R1 wrap
      wr(4'd2, 8'h00);
      set_count(16'hFFFF);
      run_ticks(2);
      read_count(v); check("R1 wrap", v, 16'h0000);

      // R3 shadow holds across a change
      set_count(16'h12FF);
      rd(4'd0, d);  check("R3 low byte", {8'h0, d}, 16'h00FF);
      run_ticks(2);
      rd(4'd1, d);  check("R3 shadow high", {8'h0, d}, 16'h0012);
      read_count(v); check("R3 fresh pair", v, 16'h1300);

      // R5/R6/R7 random captures
      for (int it = 0; it < 40; it++) begin
         logic [15:0] c  = 16'($urandom);
         int          ps = int'($urandom_range(0, 7));
         int          ch = int'($urandom_range(0, 1));
         int          idx;
         wr(4'd2, 8'(ps));
         set_count(c);
         @(negedge clk);
         cap_pin[ch] = ~cap_pin[ch];
         idx = 2 * ch + (cap_pin[ch] ? 0 : 1);
         exp_cap[idx] = exp_window(c, ps);
         exp_flags[idx] = 1'b1;
         repeat (4) @(negedge clk);
         check("R7 flag set", {12'h0, cap_irq}, {12'h0, exp_flags});
         rd(4'(4 + idx), d);     check("R5 R6 captured window", {8'h0, d}, {8'h0, exp_cap[idx]});
         rd(4'(4 + (idx ^ 1)), d); check("R6 other polarity kept", {8'h0, d}, {8'h0, exp_cap[idx ^ 1]});
         if ($urandom_range(0, 1) == 1) begin
            wr(4'd3, 8'(1 << idx));
            exp_flags[idx] = 1'b0;
            rd(4'd3, d); check("R7 clear by one", {8'h0, d}, {12'h0, exp_flags});
         end
      end

      // R5 directed top window
      wr(4'd2, 8'h07);
      set_count(16'hC080);
      @(negedge clk); cap_pin[0] = ~cap_pin[0];
      repeat (4) @(negedge clk);
      rd(cap_pin[0] ? 4'd4 : 4'd5, d); check("R5 shift 7", {8'h0, d}, 16'h0081);

      // R6 writes to capture are ignored
      rd(4'd6, d);
      wr(4'd6, ~d);
      begin
         logic [7:0] d2;
         rd(4'd6, d2); check("R6 write ignored", {8'h0, d2}, {8'h0, d});
      end

      // R9 steady pin raises nothing after clear
      wr(4'd3, 8'h0F);
      repeat (8) @(negedge clk);
      check("R9 steady level", {12'h0, cap_irq}, 16'h0);

      finish_test();
   end
endmodule